// File: doc/BRIEF.md
# Load-Instruction Step Sequencer

This block is the hardwired control unit of a small processor in which every register hangs off one shared internal bus. A step counter walks through a fixed series of control steps. In each step the block raises the enables that choose which register drives the bus and which registers capture it. It also raises the memory read strobe and the program-counter increment. The first steps fetch an instruction word into the instruction register. The remaining steps carry out a load of one operand into a destination register.

The load comes in two flavours, chosen by a mode bit of the instruction.

- In the pointer-in-memory flavour, the address field of the instruction names a memory word that holds the operand's address. The block reads that word, sends it back from the data register into the address register, and reads again.
- In the pointer-in-register flavour, a general register already holds the operand's address. That register drives the bus straight into the address register, so the pointer read is skipped.

Every memory access is followed by a wait step. The counter holds in that step until the memory signals completion. Because of this, the number of clock cycles depends on both the flavour and the memory latency.

Top module: `ldseq_ctrl`

## Requirements
- R1: While `rst_n` is low, every control output is 0. After `rst_n` rises, all outputs stay 0 for two further clock cycles, and step 1 is presented in the third cycle.
- R2: The fetch runs in steps 1 to 3 and does not depend on the opcode. Step 1 asserts `pc_out`, `mar_in`, `mem_rd` and `pc_inc`. Step 2 is a wait step with no enables. Step 3 asserts `mdr_out` and `ir_in`.
- R3: The wait steps are step 2, step 5 of a load, and step 7 of a pointer-in-memory load. A wait step holds for every cycle in which `mem_done` is sampled low. It is left on the first clock edge at which `mem_done` is sampled high. No other step ever holds.
- R4: A load is an instruction with `op_code` equal to `LOAD_OP` (default 4'h2). With `mode_mi`=1 it runs these steps:
  - step 4: `fld_out`, `mar_in`, `mem_rd`
  - step 5: wait
  - step 6: `mdr_out`, `mar_in`, `mem_rd`
  - step 7: wait
  - step 8: `mdr_out`, `dst_in`, `eoi`
- R5: A load with `mode_mi`=0 runs these steps:
  - step 4: `ptr_out`, `mar_in`, `mem_rd`
  - step 5: wait
  - step 6: `mdr_out`, `dst_in`, `eoi`
- R6: Not counting held cycles, a pointer-in-memory load takes 8 steps and a pointer-in-register load takes 6. `eoi` is high for exactly one cycle, in the final step. Step 1 follows in the next cycle.
- R7: In every cycle, at most one of `pc_out`, `fld_out`, `ptr_out` and `mdr_out` is high.
- R8: Any opcode other than `LOAD_OP` ends at step 4, with `eoi` as the only output high. The destination register and the address register are left untouched.
- R9: `mdr_out` is only ever asserted in the cycle right after a cycle in which `mem_done` was high. The destination register therefore always captures a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| op_code | input | OP_W | Opcode field of the instruction register |
| mode_mi | input | 1 | Mode bit: 1 = pointer in memory, 0 = pointer in register |
| mem_done | input | 1 | Memory completion; high for the cycle in which read data is ready |
| pc_out | output | 1 | Program counter drives the bus |
| fld_out | output | 1 | Instruction address field drives the bus |
| ptr_out | output | 1 | Pointer register drives the bus |
| mdr_out | output | 1 | Memory data register drives the bus |
| mar_in | output | 1 | Memory address register captures the bus |
| ir_in | output | 1 | Instruction register captures the bus |
| dst_in | output | 1 | Destination register captures the bus |
| mem_rd | output | 1 | Start a memory read at the bus address |
| pc_inc | output | 1 | Advance the program counter |
| eoi | output | 1 | End of instruction |

## Verification
The bench builds the block with the default parameters: `OP_W`=4, `LOAD_OP`=4'h2 and two reset synchroniser stages. Keeping the synchroniser at its default fixes the two silent cycles after reset, so the bench can predict them exactly. The bench supplies a memory and datapath model whose read latency rotates through 1 to 4 cycles. With this rotation, every wait step is seen both without holding and with holds of up to three cycles, in both load flavours and for non-load opcodes. The destination value, program counter and held-cycle count are then compared after every instruction.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;
  localparam int STEP_W = 4;

  typedef struct packed {
    logic pc_out;
    logic fld_out;
    logic ptr_out;
    logic mdr_out;
    logic mar_in;
    logic ir_in;
    logic dst_in;
    logic mem_rd;
    logic pc_inc;
    logic wait_mem;
    logic eoi;
  } ctrl_t;

  localparam ctrl_t CTRL_NONE = '0;
endpackage

// File: rtl/ldseq_rst_sync.sv
module ldseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ldseq_step_ctr.sv
module ldseq_step_ctr
  import ldseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              eoi,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] STEP_IDLE  = '0;
  localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(1);

  logic [STEP_W-1:0] step_d;
  logic              step_en;

  always_comb begin
    step_en = 1'b1;
    step_d  = step + STEP_W'(1);
    if (step == STEP_IDLE) begin
      step_d = STEP_FIRST;
    end else if (eoi) begin
      step_d = STEP_FIRST;
    end else if (stall) begin
      step_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= STEP_IDLE;
    else if (step_en) step <= step_d;
  end

  // R3
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !eoi && step != STEP_IDLE) |=> $stable(step));

  // R6
  restart_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> (step == STEP_FIRST));
endmodule

// File: rtl/ldseq_decode.sv
module ldseq_decode
  import ldseq_pkg::*;
#(
  parameter int              OP_W    = 4,
  parameter logic [OP_W-1:0] LOAD_OP = OP_W'(2)
) (
  input  logic [STEP_W-1:0] step,
  input  logic [OP_W-1:0]   op_code,
  input  logic              mode_mi,
  input  logic              mem_done,
  output ctrl_t             ctrl,
  output logic              stall
);
  logic is_load;

  assign is_load = (op_code == LOAD_OP);

  always_comb begin
    ctrl = CTRL_NONE;
    case (step)
      STEP_W'(1): begin
        ctrl.pc_out = 1'b1;
        ctrl.mar_in = 1'b1;
        ctrl.mem_rd = 1'b1;
        ctrl.pc_inc = 1'b1;
      end
      STEP_W'(2): ctrl.wait_mem = 1'b1;
      STEP_W'(3): begin
        ctrl.mdr_out = 1'b1;
        ctrl.ir_in   = 1'b1;
      end
      STEP_W'(4): begin
        if (!is_load) begin
          ctrl.eoi = 1'b1;
        end else begin
          ctrl.fld_out = mode_mi;
          ctrl.ptr_out = !mode_mi;
          ctrl.mar_in  = 1'b1;
          ctrl.mem_rd  = 1'b1;
        end
      end
      STEP_W'(5): ctrl.wait_mem = is_load;
      STEP_W'(6): begin
        if (is_load) begin
          ctrl.mdr_out = 1'b1;
          ctrl.mar_in  = mode_mi;
          ctrl.mem_rd  = mode_mi;
          ctrl.dst_in  = !mode_mi;
          ctrl.eoi     = !mode_mi;
        end
      end
      STEP_W'(7): ctrl.wait_mem = is_load && mode_mi;
      STEP_W'(8): begin
        if (is_load && mode_mi) begin
          ctrl.mdr_out = 1'b1;
          ctrl.dst_in  = 1'b1;
          ctrl.eoi     = 1'b1;
        end
      end
      default: ctrl = CTRL_NONE;
    endcase
  end

  assign stall = ctrl.wait_mem && !mem_done;
endmodule

// File: rtl/ldseq_ctrl.sv
module ldseq_ctrl
  import ldseq_pkg::*;
#(
  parameter int              OP_W        = 4,
  parameter logic [OP_W-1:0] LOAD_OP     = OP_W'(2),
  parameter int              SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_code,
  input  logic            mode_mi,
  input  logic            mem_done,
  output logic            pc_out,
  output logic            fld_out,
  output logic            ptr_out,
  output logic            mdr_out,
  output logic            mar_in,
  output logic            ir_in,
  output logic            dst_in,
  output logic            mem_rd,
  output logic            pc_inc,
  output logic            eoi
);
  logic              rst_n_sync;
  logic [STEP_W-1:0] step;
  logic              stall;
  ctrl_t             ctrl;

  ldseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ldseq_step_ctr u_step_ctr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .stall (stall),
    .eoi   (ctrl.eoi),
    .step  (step)
  );

  ldseq_decode #(.OP_W(OP_W), .LOAD_OP(LOAD_OP)) u_decode (
    .step     (step),
    .op_code  (op_code),
    .mode_mi  (mode_mi),
    .mem_done (mem_done),
    .ctrl     (ctrl),
    .stall    (stall)
  );

  assign pc_out  = ctrl.pc_out;
  assign fld_out = ctrl.fld_out;
  assign ptr_out = ctrl.ptr_out;
  assign mdr_out = ctrl.mdr_out;
  assign mar_in  = ctrl.mar_in;
  assign ir_in   = ctrl.ir_in;
  assign dst_in  = ctrl.dst_in;
  assign mem_rd  = ctrl.mem_rd;
  assign pc_inc  = ctrl.pc_inc;
  assign eoi     = ctrl.eoi;

  // R7
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0({pc_out, fld_out, ptr_out, mdr_out}));

  // R9
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mdr_out |-> $past(mem_done));

  // R6
  eoi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    eoi |=> (!eoi && pc_out));

  // R3
  read_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_rd |=> !mem_rd);
endmodule

// File: tb/ldseq_ctrl_tb.sv
module ldseq_ctrl_tb;
  localparam int         OP_W    = 4;
  localparam logic [3:0] LOAD_OP = 4'h2;
  localparam int         NINSTR  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OP_W-1:0] op_code = '0;
  logic mode_mi = 1'b0;
  logic mem_done = 1'b0;
  logic pc_out, fld_out, ptr_out, mdr_out, mar_in, ir_in, dst_in, mem_rd, pc_inc, eoi;

  always #4 clk = ~clk;

  ldseq_ctrl #(.OP_W(OP_W), .LOAD_OP(LOAD_OP), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .mode_mi(mode_mi), .mem_done(mem_done),
    .pc_out(pc_out), .fld_out(fld_out), .ptr_out(ptr_out), .mdr_out(mdr_out),
    .mar_in(mar_in), .ir_in(ir_in), .dst_in(dst_in), .mem_rd(mem_rd),
    .pc_inc(pc_inc), .eoi(eoi)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] mem [256];
  logic [15:0] pc, mar, mdr, ir, rdst, bus;
  logic [3:0]  op_k [NINSTR];
  logic        md_k [NINSTR];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bit order: pc_out fld_out ptr_out mdr_out mar_in ir_in dst_in mem_rd pc_inc eoi
  function automatic logic [9:0] spec(int st, logic [3:0] op, logic md);
    logic [9:0] e;
    bit ld;
    ld = (op == LOAD_OP);
    e = '0;
    if (st == 1) e = 10'b1000100110;
    else if (st == 3) e = 10'b0001010000;
    else if (st == 4 && !ld) e = 10'b0000000001;
    else if (st == 4 && md) e = 10'b0100100100;
    else if (st == 4) e = 10'b0010100100;
    else if (st == 6 && ld && md) e = 10'b0001100100;
    else if (st == 6 && ld) e = 10'b0001001001;
    else if (st == 8 && ld && md) e = 10'b0001001001;
    return e;
  endfunction

  function automatic string req_of(int st, logic [3:0] op, logic md);
    if (st < 1) return "R1";
    if (st == 2) return "R3";
    if (st <= 3) return "R2";
    if (op != LOAD_OP) return "R8";
    if (st == 5 || st == 7) return "R3";
    return md ? "R4" : "R5";
  endfunction

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] obs, ex;
    logic [15:0] r_before, mar_before;
    int ref_step, k, acc_idx, cnt, lat, maddr, cyc, stall_exp;
    bit started, md_next, ld;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    for (int i = 0; i < NINSTR; i++) begin
      op_k[i] = (i == 4) ? 4'h7 : (i == 7) ? 4'hF : LOAD_OP;
      md_k[i] = (i % 2 == 0);
      mem[i] = {op_k[i], md_k[i], 3'b000, 8'(32 + i)};
      mem[32 + i]  = 16'(160 + i);
      mem[160 + i] = 16'hC300 + 16'(i * 41);
      mem[96 + i]  = 16'h5A00 + 16'(i * 13);
    end
    pc = 0; mar = 0; mdr = 0; ir = 0; rdst = 16'hDEAD;
    k = 0; acc_idx = 0; cnt = 0; maddr = 0; cyc = 0; stall_exp = 0;
    started = 0; md_next = 0;
    r_before = rdst; mar_before = mar;

    // R1: outputs low while reset is held
    repeat (3) begin
      @(negedge clk);
      chk({pc_out, fld_out, ptr_out, mdr_out, mar_in, ir_in, dst_in, mem_rd, pc_inc, eoi} == 10'd0,
          "R1", "outputs in reset", 32'({pc_out, mar_in, mem_rd, eoi}), 32'd0);
    end
    rst_n = 1'b1;
    ref_step = -1;

    while (k < NINSTR) begin
      @(posedge clk);
      #1;
      mem_done = md_next;
      op_code  = ir[15:12];
      mode_mi  = ir[11];
      @(negedge clk);
      obs = {pc_out, fld_out, ptr_out, mdr_out, mar_in, ir_in, dst_in, mem_rd, pc_inc, eoi};
      ex  = (ref_step >= 1) ? spec(ref_step, ir[15:12], ir[11]) : 10'd0;
      chk(obs == ex, req_of(ref_step, ir[15:12], ir[11]),
          $sformatf("controls at step %0d", ref_step), 32'(obs), 32'(ex));
      chk($countones({pc_out, fld_out, ptr_out, mdr_out}) <= 1, "R7", "bus drivers",
          32'({pc_out, fld_out, ptr_out, mdr_out}), 32'd1);

      if (pc_out) started = 1;
      if (started) cyc++;

      // datapath model
      bus = pc_out ? pc : fld_out ? {8'h00, ir[7:0]} : ptr_out ? 16'(96 + k) : mdr_out ? mdr : 16'h0;
      if (pc_inc) pc = pc + 1;
      if (mar_in) mar = bus;
      if (ir_in)  ir  = bus;
      if (dst_in) rdst = bus;
      if (mem_done) mdr = mem[maddr];
      if (mem_rd) begin
        lat = 1 + (acc_idx % 4);
        acc_idx++;
        cnt = lat;
        maddr = int'(bus[7:0]);
        stall_exp += lat - 1;
      end else if (cnt > 0) begin
        cnt--;
      end
      md_next = (cnt == 1) && (mem_rd || cnt == 1);

      // reference step update
      ld = (ir[15:12] == LOAD_OP);
      if (ref_step < 1) begin
        ref_step++;
      end else if ((ref_step == 2 || (ld && ref_step == 5) || (ld && ir[11] && ref_step == 7))
                   && !mem_done) begin
        ref_step = ref_step;
      end else if (ex[0]) begin
        ref_step = 1;
      end else begin
        ref_step++;
      end

      if (eoi) begin
        if (op_k[k] == LOAD_OP && md_k[k]) begin
          chk(rdst == mem[160 + k], "R4", "operand via memory pointer", 32'(rdst), 32'(mem[160 + k]));
          chk(cyc - stall_exp == 8, "R6", "steps of memory-pointer load", 32'(cyc - stall_exp), 32'd8);
        end else if (op_k[k] == LOAD_OP) begin
          chk(rdst == mem[96 + k], "R5", "operand via register pointer", 32'(rdst), 32'(mem[96 + k]));
          chk(cyc - stall_exp == 6, "R6", "steps of register-pointer load", 32'(cyc - stall_exp), 32'd6);
        end else begin
          chk(rdst == r_before, "R8", "destination untouched", 32'(rdst), 32'(r_before));
          chk(mar == mar_before, "R8", "address register untouched", 32'(mar), 32'(mar_before));
          chk(cyc - stall_exp == 4, "R8", "steps of non-load", 32'(cyc - stall_exp), 32'd4);
        end
        chk(pc == 16'(k + 1), "R2", "program counter advanced", 32'(pc), 32'(k + 1));
        k++;
        cyc = 0;
        stall_exp = 0;
        r_before = rdst;
      end
      if (ir_in) mar_before = mar;
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule